// File: doc/BRIEF.md
# Parallel Bit Gather Unit

This execution unit takes a source word and a selection mask. It collects every source bit whose mask bit is set and packs those bits, in their original order, into the lowest positions of the result. The selected bits need not be adjacent. All result positions above the packed group are zero. The unit is one registered stage: a request presented with `inValid` high produces `outValid`, the packed `result` and the `illegalOp` flag one clock later.

The operand size is 64 bits only when the core is in 64-bit mode and the width-select input is set. In every other case the operation uses 32 bits: only the low halves of the source and mask are read, and result bits 63:32 are zero.

A non-zero vector-length field marks the request as illegal. In that case the unit raises `illegalOp` alongside `outValid` and leaves the result register unchanged. The unit has no condition-flag outputs.

Top module: `bit_gather_unit`

## Requirements
- R1: The mask is scanned from bit 0 upward. The source bit under each set mask bit goes to the next free result position, starting at result bit 0, so a lower selected bit always lands lower in the result.
- R2: Every result bit above the last filled position is 0.
- R3: A 64-bit operation happens when `longMode`=1 and `wideSel`=1. In every other case the operation is 32-bit: source and mask bits 63:32 are not used and result bits 63:32 are 0.
- R4: When `longMode`=0, `wideSel` has no effect on the result.
- R5: When a valid request has `lenField` not equal to 0, `illegalOp` is 1 with `outValid` in the next cycle and `result` keeps its previous value.
- R6: `outValid` equals `inValid` delayed by exactly one clock. `result` and `illegalOp` are due in the same cycle as `outValid`.
- R7: An all-zero mask gives a zero result. An all-ones mask gives the source truncated to the operand width.
- R8: While `rstN` is low at a clock edge, `outValid`, `illegalOp` and `result` are cleared to 0.
- R9: A cycle without `inValid` leaves `result` unchanged and makes `illegalOp` 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request valid |
| srcData | input | 64 | Source word |
| maskData | input | 64 | Selection mask |
| longMode | input | 1 | Core is in 64-bit mode |
| wideSel | input | 1 | Requests 64-bit operand size (honoured only in 64-bit mode) |
| lenField | input | 2 | Vector-length field; must be 0 |
| outValid | output | 1 | Result valid, one cycle after `inValid` |
| result | output | 64 | Packed result register |
| illegalOp | output | 1 | Request had a non-zero length field |

## Verification
Every output of the unit is due on the first rising edge after the request is presented. The bench drives each request on a falling edge, drops `inValid` on the next falling edge, and samples `outValid`, `result` and `illegalOp` at that moment, half a cycle after the capturing edge. Idle cycles are sampled on the falling edge after that, to confirm that `outValid` falls and `result` is held. Expected results come from a bit-serial loop in the bench, run over directed corner masks, every mode and width combination, and random words.

// File: rtl/bit_gather_pkg.sv
package bit_gather_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic isWide;      // 64-bit operand size selected
    logic loadResult;  // legal valid request: update result register
  } gatherStrobes_t;
endpackage

// File: rtl/bit_gather_ctrl.sv
module bit_gather_ctrl
  import bit_gather_pkg::*;
#(
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             longMode,
  input  logic             wideSel,
  input  logic [LEN_W-1:0] lenField,
  output gatherStrobes_t   strobes,
  output logic             outValid,
  output logic             illegalOp
);
  logic lenBad;

  always_comb begin
    lenBad             = |lenField;
    // R3/R4: wide only in 64-bit mode with select set
    strobes.isWide     = longMode & wideSel;
    // R5/R9: update only on a legal valid request
    strobes.loadResult = inValid & ~lenBad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      outValid  <= inValid;
      illegalOp <= inValid & lenBad;
    end
  end
endmodule

// File: rtl/bit_gather_dp.sv
module bit_gather_dp
  import bit_gather_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic           clk,
  input  logic           rstN,
  input  gatherStrobes_t strobes,
  input  logic [DW-1:0]  srcData,
  input  logic [DW-1:0]  maskData,
  output logic [DW-1:0]  result
);
  localparam int HW = DW / 2;
  localparam int IW = $clog2(DW);
  localparam int CW = IW + 1;

  logic [DW-1:0] effMask;
  logic [CW-1:0] rank [DW];
  logic [DW-1:0] packedBits;

  // R3: narrow operation drops upper mask bits, which also zeroes result[63:32]
  always_comb begin
    effMask = strobes.isWide ? maskData : {{HW{1'b0}}, maskData[HW-1:0]};
  end

  // Prefix count: rank[i] = number of set mask bits below position i
  assign rank[0] = '0;
  for (genvar i = 1; i < DW; i++) begin : g_rank
    assign rank[i] = rank[i-1] + CW'(effMask[i-1]);
  end

  // Compress network (R1, R2): each selected bit lands at its rank
  always_comb begin
    packedBits = '0;
    for (int i = 0; i < DW; i++) begin
      if (effMask[i]) packedBits[rank[i][IW-1:0]] = srcData[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   result <= '0;
    else if (strobes.loadResult) result <= packedBits;
  end
endmodule

// File: rtl/bit_gather_unit.sv
module bit_gather_unit
  import bit_gather_pkg::*;
#(
  parameter int DW    = 64,
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [DW-1:0]    srcData,
  input  logic [DW-1:0]    maskData,
  input  logic             longMode,
  input  logic             wideSel,
  input  logic [LEN_W-1:0] lenField,
  output logic             outValid,
  output logic [DW-1:0]    result,
  output logic             illegalOp
);
  gatherStrobes_t strobes;

  bit_gather_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .longMode(longMode),
    .wideSel(wideSel), .lenField(lenField), .strobes(strobes),
    .outValid(outValid), .illegalOp(illegalOp)
  );

  bit_gather_dp #(.DW(DW)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srcData(srcData),
    .maskData(maskData), .result(result)
  );
endmodule

// File: rtl/bit_gather_chk.sv
module bit_gather_chk #(
  parameter int DW    = 64,
  parameter int LEN_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [DW-1:0]    maskData,
  input logic             longMode,
  input logic             wideSel,
  input logic [LEN_W-1:0] lenField,
  input logic             outValid,
  input logic [DW-1:0]    result,
  input logic             illegalOp
);
  localparam int HW = DW / 2;

  p_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_hold_illegal_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && lenField != '0) |=> (illegalOp && $stable(result)));
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!illegalOp && $stable(result)));
  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && lenField == '0 && !(longMode && wideSel)) |=> result[DW-1:HW] == '0);
  p_zero_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && lenField == '0 && maskData == '0) |=> result == '0);
  p_reset_r8: assert property (@(posedge clk)
    !rstN |=> (!outValid && !illegalOp && result == '0));
endmodule

bind bit_gather_unit bit_gather_chk #(.DW(DW), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .maskData(maskData),
  .longMode(longMode), .wideSel(wideSel), .lenField(lenField),
  .outValid(outValid), .result(result), .illegalOp(illegalOp)
);

// File: tb/bit_gather_unit_tb.sv
`timescale 1ns/1ps
module bit_gather_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] srcData = '0;
  logic [63:0] maskData = '0;
  logic        longMode = 1'b0;
  logic        wideSel = 1'b0;
  logic [1:0]  lenField = '0;
  logic        outValid;
  logic [63:0] result;
  logic        illegalOp;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  bit_gather_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcData(srcData),
    .maskData(maskData), .longMode(longMode), .wideSel(wideSel),
    .lenField(lenField), .outValid(outValid), .result(result),
    .illegalOp(illegalOp)
  );

  function automatic logic [63:0] refGather(input logic [63:0] s, input logic [63:0] m,
                                            input logic wide);
    logic [63:0] r = '0;
    int k = 0;
    for (int b = 0; b < (wide ? 64 : 32); b++) begin
      if (m[b]) begin
        r[k] = s[b];
        k++;
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Present one request on a falling edge; sample half a cycle after capture.
  task automatic apply(input logic [63:0] s, input logic [63:0] m, input logic lm,
                       input logic ws, input logic [1:0] len);
    @(negedge clk);
    srcData = s; maskData = m; longMode = lm; wideSel = ws; lenField = len;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic runOp(input string tag, input logic [63:0] s, input logic [63:0] m,
                       input logic lm, input logic ws);
    apply(s, m, lm, ws, 2'd0);
    check({tag, " R6 outValid"}, {63'd0, outValid}, 64'd1);
    check({tag, " R1 result"}, result, refGather(s, m, lm & ws));
  endtask

  task automatic testReset();
    check("R8 outValid after reset", {63'd0, outValid}, 64'd0);
    check("R8 illegalOp after reset", {63'd0, illegalOp}, 64'd0);
    check("R8 result after reset", result, 64'd0);
  endtask

  task automatic testCorners();
    logic [63:0] s = 64'hA5C3_0F96_5A3C_F069;
    runOp("R7 zero mask wide", s, 64'd0, 1'b1, 1'b1);
    check("R7 zero mask value", result, 64'd0);
    runOp("R7 ones mask wide", s, '1, 1'b1, 1'b1);
    check("R7 ones wide equals src", result, s);
    runOp("R7 ones mask narrow", s, '1, 1'b1, 1'b0);
    check("R7 ones narrow truncates", result, {32'd0, s[31:0]});
    for (int w = 0; w < 2; w++) begin
      runOp("R2 single bit0", 64'h1, 64'h1, 1'b1, w[0]);
      runOp("R2 single bit31", 64'h8000_0000, 64'h8000_0000, 1'b1, w[0]);
      runOp("R3 single bit63", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1, w[0]);
    end
    runOp("R1 order", 64'h0000_0000_0000_0050, 64'h0000_0000_0000_00F0, 1'b1, 1'b1);
    check("R1 order value", result, 64'h5);
  endtask

  task automatic testModes();
    logic [63:0] s = 64'hFFFF_0000_1234_ABCD;
    logic [63:0] m = 64'hF0F0_F0F0_0F0F_0F0F;
    runOp("R3 long wide", s, m, 1'b1, 1'b1);
    runOp("R3 long narrow", s, m, 1'b1, 1'b0);
    check("R3 narrow upper zero", {32'd0, result[63:32]}, 64'd0);
    runOp("R4 legacy sel0", s, m, 1'b0, 1'b0);
    runOp("R4 legacy sel1", s, m, 1'b0, 1'b1);
    check("R4 legacy ignores sel", result, refGather(s, m, 1'b0));
  endtask

  task automatic testIllegal();
    logic [63:0] prev;
    runOp("R5 setup", 64'hDEAD_BEEF_CAFE_F00D, 64'h0F0F_0F0F_0F0F_0F0F, 1'b1, 1'b1);
    prev = result;
    for (int l = 1; l < 4; l++) begin
      apply(64'h1111_2222_3333_4444, '1, 1'b1, 1'b1, 2'(l));
      check("R5 illegal flag", {63'd0, illegalOp}, 64'd1);
      check("R5 outValid with illegal", {63'd0, outValid}, 64'd1);
      check("R5 result held", result, prev);
    end
    @(negedge clk);
    check("R9 idle illegal low", {63'd0, illegalOp}, 64'd0);
    check("R9 idle outValid low", {63'd0, outValid}, 64'd0);
    check("R9 idle result held", result, prev);
  endtask

  task automatic testIdleHold();
    logic [63:0] prev;
    runOp("R9 setup", 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000, 1'b1, 1'b1);
    prev = result;
    @(negedge clk);
    srcData = '1; maskData = '1;  // change data without inValid
    @(negedge clk);
    check("R9 data without valid ignored", result, prev);
    check("R6 no valid no outValid", {63'd0, outValid}, 64'd0);
  endtask

  task automatic testRandom();
    for (int n = 0; n < 300; n++) begin
      logic [63:0] s = {$urandom, $urandom};
      logic [63:0] m = {$urandom, $urandom};
      logic [1:0] md = 2'($urandom);
      runOp("R1 random", s, m, md[1], md[0]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testCorners();
    testModes();
    testIllegal();
    testIdleHold();
    testRandom();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule